// File: doc/BRIEF.md
# Precise Trap Pipeline Controller

This block is the control skeleton of a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. It moves one instruction slot forward per cycle and never stalls. Each slot holds a valid bit, the instruction's program counter and a cause code. Fault sources outside the block report through one strobe per stage. The strobe marks the instruction that currently sits in that stage, and the mark then travels with that instruction. Nothing acts on a mark before the instruction reaches writeback. As a result, the oldest faulting instruction always wins, and every exception has a single restart point.

When a marked slot reaches writeback, the block does five things. It records the slot's PC and cause, sends fetch to a fixed vector, sets the supervisor mode bit and squashes every younger slot. The marked instruction does not commit. An external interrupt request turns the next fetched slot into a tagged no-op bubble. If that bubble is squashed, the request line is still high, so the interrupt is injected again. A return strobe resumes fetch at the recorded PC, flushes the pipeline and drops back to user mode.

Top module: `precise_trap_pipe`

## Requirements
- R1: The bits of `stage_fault` apply, from bit 0 to bit 3, to the slot in fetch, decode, execute and memory. A strobe on a valid, unmarked slot marks it with cause 1 (fetch translation fault), 2 (illegal instruction), 3 (arithmetic overflow) or 4 (data translation fault). A strobe on an empty stage has no effect.
- R2: A mark takes effect only at writeback. `trap_taken` is high in the one cycle in which the marked slot sits in writeback. That is exactly five rising edges after it was fetched.
- R3: When several in-flight slots are marked, the trap is taken for the oldest one, whatever the order in time in which the marks were raised.
- R4: A slot that is already marked keeps its first cause. Strobes in later stages do not change that cause.
- R5: On the edge after `trap_taken`: `epc` holds the marked slot's PC, `ecause` holds its cause, `sup_mode` is 1 and `fetch_pc` is the vector 0x80.
- R6: A marked slot never commits, and no slot younger than it commits. Every older slot has already committed.
- R7: While `irq_req` is high and `sup_mode` is 0, the next fetched slot becomes a no-op with cause 5 that carries the PC it replaced. The resulting `epc` points at that instruction. While `sup_mode` is 1, no interrupt is injected.
- R8: A one-cycle `eret` loads `fetch_pc` from `epc`, invalidates every stage and clears `sup_mode`. The first commit after it is the instruction at `epc`, five edges later. If `eret` and `trap_taken` are high together, the trap takes priority.
- R9: While `rst_n` is low, these outputs are all zero: `fetch_pc`, `commit_valid`, `trap_taken`, `epc`, `ecause` and `sup_mode`.
- R10: Unmarked instructions commit in program order, with PCs that rise by 4 from one commit to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_fault | input | 4 | Per-stage fault strobes: fetch, decode, execute, memory (bits 0..3) |
| irq_req | input | 1 | Level-sensitive external interrupt request |
| eret | input | 1 | Return-from-exception strobe |
| fetch_pc | output | 32 | PC of the next instruction to be fetched |
| commit_valid | output | 1 | A clean instruction retires this cycle |
| commit_pc | output | 32 | PC of the slot in writeback |
| trap_taken | output | 1 | A marked slot is in writeback this cycle |
| epc | output | 32 | Recorded exception PC |
| ecause | output | 3 | Recorded cause code |
| sup_mode | output | 1 | 1 = supervisor, 0 = user |

## Verification
The hardest case to reach from the ports is a younger instruction that is marked earlier in time than an older one. An example is a fetch fault on one instruction raised before the memory fault of the instruction ahead of it. Only the older mark may win. The stimulus table sets up this case by timing each strobe from the target PC's fetch cycle plus its stage depth. Other rows place two strobes on the same slot, or start an interrupt while an older slot is already marked. A directed run holds the interrupt line high through the handler to show that injection is masked, then returns and checks the flush delay.

// File: rtl/ptrap_pkg.sv
// Shared types for the precise trap pipeline.
// Assumes a fixed 32-bit PC; the cause codes are part of the block's interface.
package ptrap_pkg;
    localparam int PC_W   = 32;
    localparam int N_PIPE = 4;   // stages after fetch

    typedef enum logic [2:0] {
        CZ_NONE    = 3'd0,
        CZ_IFAULT  = 3'd1,
        CZ_ILLEGAL = 3'd2,
        CZ_OVF     = 3'd3,
        CZ_DFAULT  = 3'd4,
        CZ_IRQ     = 3'd5
    } cause_e;

    typedef struct packed {
        logic            valid;
        logic [PC_W-1:0] pc;
        cause_e          cause;
    } slot_t;
endpackage

// File: rtl/pipe_stage.sv
// One pipeline register. It takes the slot from the previous stage and merges
// in that stage's fault strobe, but only when the slot is valid and not yet marked.
// Assumes the slot advances every cycle; kill empties the register.
module pipe_stage #(
    parameter ptrap_pkg::cause_e FAULT_CODE = ptrap_pkg::CZ_IFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  ptrap_pkg::slot_t  in_slot,
    input  logic              fault,
    output ptrap_pkg::slot_t  out_slot
);
    import ptrap_pkg::*;

    logic   take_fault;
    cause_e next_cause;

    // Decide whether this stage contributes the first cause.
    always_comb begin
        take_fault = in_slot.valid && (in_slot.cause == CZ_NONE) && fault;
        next_cause = take_fault ? FAULT_CODE : in_slot.cause;
    end

    // Advance the slot, or empty it on reset or squash.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            out_slot.valid <= 1'b0;
            out_slot.pc    <= '0;
            out_slot.cause <= CZ_NONE;
        end else begin
            out_slot.valid <= in_slot.valid;
            out_slot.pc    <= in_slot.pc;
            out_slot.cause <= next_cause;
        end
    end

    // R1
    fault_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot.valid && in_slot.cause == CZ_NONE && fault && !kill)
        |=> (out_slot.valid && out_slot.cause == FAULT_CODE));

    // R4
    first_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot.valid && in_slot.cause != CZ_NONE && !kill)
        |=> (out_slot.cause == $past(in_slot.cause)));
endmodule

// File: rtl/fetch_unit.sv
// Fetch PC and the fetch-stage slot. It issues one sequential PC per cycle.
// While an interrupt is pending in user mode, it turns the fetched slot into a
// tagged bubble. A redirect empties the fetch slot and reloads the PC.
module fetch_unit #(
    parameter logic [ptrap_pkg::PC_W-1:0] RESET_PC = '0,
    parameter int                         PC_STEP  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       redirect,
    input  logic [ptrap_pkg::PC_W-1:0] redirect_pc,
    input  logic                       irq_req,
    input  logic                       sup_mode,
    output logic [ptrap_pkg::PC_W-1:0] fetch_pc,
    output ptrap_pkg::slot_t           if_slot
);
    import ptrap_pkg::*;

    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    logic inject;

    // An interrupt may only replace a fetch in user mode.
    always_comb inject = irq_req && !sup_mode;

    // Keep the program counter: a redirect wins, otherwise it advances.
    always_ff @(posedge clk) begin
        if (!rst_n)        fetch_pc <= RESET_PC;
        else if (redirect) fetch_pc <= redirect_pc;
        else               fetch_pc <= fetch_pc + STEP;
    end

    // Fill the fetch slot with the current PC, tagged when an interrupt is injected.
    always_ff @(posedge clk) begin
        if (!rst_n || redirect) begin
            if_slot.valid <= 1'b0;
            if_slot.pc    <= '0;
            if_slot.cause <= CZ_NONE;
        end else begin
            if_slot.valid <= 1'b1;
            if_slot.pc    <= fetch_pc;
            if_slot.cause <= inject ? CZ_IRQ : CZ_NONE;
        end
    end

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (if_slot.valid && if_slot.cause == CZ_IRQ) |-> $past(irq_req && !sup_mode));
endmodule

// File: rtl/trap_unit.sv
// Writeback resolution. It commits clean slots. For a marked slot it records the
// PC and cause and enters supervisor mode. A return clears the mode bit.
// Assumes a trap in writeback outranks a simultaneous return.
module trap_unit (
    input  logic                       clk,
    input  logic                       rst_n,
    input  ptrap_pkg::slot_t           wb_slot,
    input  logic                       eret,
    output logic                       trap_taken,
    output logic                       commit_valid,
    output logic [ptrap_pkg::PC_W-1:0] epc,
    output ptrap_pkg::cause_e          ecause,
    output logic                       sup_mode
);
    import ptrap_pkg::*;

    // Classify the slot in writeback.
    always_comb begin
        trap_taken   = wb_slot.valid && (wb_slot.cause != CZ_NONE);
        commit_valid = wb_slot.valid && (wb_slot.cause == CZ_NONE);
    end

    // Record the restart point and cause when a trap is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc    <= '0;
            ecause <= CZ_NONE;
        end else if (trap_taken) begin
            epc    <= wb_slot.pc;
            ecause <= wb_slot.cause;
        end
    end

    // Privilege bit: set on a trap, cleared on a return.
    always_ff @(posedge clk) begin
        if (!rst_n)          sup_mode <= 1'b0;
        else if (trap_taken) sup_mode <= 1'b1;
        else if (eret)       sup_mode <= 1'b0;
    end

    // R5
    epc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> (epc == $past(wb_slot.pc) && ecause == $past(wb_slot.cause)));
endmodule

// File: rtl/precise_trap_pipe.sv
// Top of the precise trap pipeline. It chains the fetch slot through four
// pipe_stage registers (decode, execute, memory, writeback). Each stage boundary
// takes the fault strobe of the stage being left. Writeback resolves traps.
// A trap or a return flushes every stage and redirects fetch.
// Assumes no stalls: every slot moves forward one stage per cycle.
module precise_trap_pipe #(
    parameter logic [ptrap_pkg::PC_W-1:0] VECTOR   = 32'h0000_0080,
    parameter logic [ptrap_pkg::PC_W-1:0] RESET_PC = 32'h0000_0000,
    parameter int                         PC_STEP  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ptrap_pkg::N_PIPE-1:0]   stage_fault,
    input  logic                           irq_req,
    input  logic                           eret,
    output logic [ptrap_pkg::PC_W-1:0]     fetch_pc,
    output logic                           commit_valid,
    output logic [ptrap_pkg::PC_W-1:0]     commit_pc,
    output logic                           trap_taken,
    output logic [ptrap_pkg::PC_W-1:0]     epc,
    output logic [2:0]                     ecause,
    output logic                           sup_mode
);
    import ptrap_pkg::*;

    localparam int LAST = N_PIPE;

    slot_t           chain [0:LAST];
    logic            flush;
    logic [PC_W-1:0] redirect_pc;
    cause_e          ecause_q;

    // Choose the fetch redirect: the vector on a trap, the saved PC on a return.
    always_comb begin
        flush       = trap_taken || eret;
        redirect_pc = trap_taken ? VECTOR : epc;
    end

    fetch_unit #(.RESET_PC(RESET_PC), .PC_STEP(PC_STEP)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .redirect    (flush),
        .redirect_pc (redirect_pc),
        .irq_req     (irq_req),
        .sup_mode    (sup_mode),
        .fetch_pc    (fetch_pc),
        .if_slot     (chain[0])
    );

    for (genvar i = 0; i < N_PIPE; i++) begin : g_stage
        pipe_stage #(.FAULT_CODE(cause_e'(i + 1))) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .kill     (flush),
            .in_slot  (chain[i]),
            .fault    (stage_fault[i]),
            .out_slot (chain[i+1])
        );
    end

    trap_unit u_trap (
        .clk          (clk),
        .rst_n        (rst_n),
        .wb_slot      (chain[LAST]),
        .eret         (eret),
        .trap_taken   (trap_taken),
        .commit_valid (commit_valid),
        .epc          (epc),
        .ecause       (ecause_q),
        .sup_mode     (sup_mode)
    );

    // Drive the writeback PC and the cause code onto the ports.
    always_comb begin
        commit_pc = chain[LAST].pc;
        ecause    = ecause_q;
    end

    // R6
    squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> (!chain[0].valid && !chain[1].valid && !chain[2].valid
                        && !chain[3].valid && !chain[4].valid));

    // R5
    vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> (fetch_pc == VECTOR && sup_mode));

    // R8
    eret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !trap_taken) |=> (fetch_pc == $past(epc) && !sup_mode && !commit_valid));

    // R10
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && $past(commit_valid)) |-> (commit_pc == $past(commit_pc) + PC_W'(PC_STEP)));
endmodule

// File: tb/tb_precise_trap_pipe.sv
`timescale 1ns/1ps
module tb_precise_trap_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  stage_fault = '0;
    logic        irq_req = 1'b0;
    logic        eret = 1'b0;
    logic [31:0] fetch_pc, commit_pc, epc;
    logic        commit_valid, trap_taken, sup_mode;
    logic [2:0]  ecause;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [31:0] VEC = 32'h80;
    localparam int NONE = 99;
    localparam int NV = 9;
    // Columns: fault1 index, fault1 stage, fault2 index, fault2 stage,
    // irq start index, expected cause, expected winner index.
    // An index k means the instruction at PC 4*k. Stage 0..3 = fetch..memory.
    localparam int TBL [0:NV-1][0:6] = '{
        '{2,    0,    NONE, NONE, NONE, 1, 2},  // R1 fetch fault
        '{3,    1,    NONE, NONE, NONE, 2, 3},  // R1 illegal in decode
        '{1,    2,    NONE, NONE, NONE, 3, 1},  // R1 overflow in execute
        '{4,    3,    NONE, NONE, NONE, 4, 4},  // R1 data fault in memory
        '{NONE, NONE, NONE, NONE, 3,    5, 3},  // R7 interrupt bubble
        '{2,    3,    3,    0,    NONE, 4, 2},  // R3 younger marked first in time
        '{2,    0,    2,    2,    NONE, 1, 2},  // R4 second strobe on same slot
        '{1,    2,    NONE, NONE, 3,    3, 1},  // R3 older fault beats interrupt
        '{0,    1,    NONE, NONE, NONE, 2, 0}   // R1 first instruction
    };

    precise_trap_pipe dut (
        .clk(clk), .rst_n(rst_n), .stage_fault(stage_fault), .irq_req(irq_req),
        .eret(eret), .fetch_pc(fetch_pc), .commit_valid(commit_valid),
        .commit_pc(commit_pc), .trap_taken(trap_taken), .epc(epc),
        .ecause(ecause), .sup_mode(sup_mode)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Holds reset for two edges and checks the reset state before releasing it.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; stage_fault = '0; irq_req = 1'b0; eret = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(fetch_pc == 0 && !commit_valid && !trap_taken && epc == 0 && ecause == 0 && !sup_mode,
            "R9 reset state", {fetch_pc[27:0], commit_valid, trap_taken, sup_mode, 1'b0}, 0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 5000, 0);
        finish_run();
    end

    initial begin : main
        int seen, trap_e, ncommit, order_ok, vec_ok;
        // Table-driven trap scenarios
        for (int v = 0; v < NV; v++) begin
            do_reset();
            seen = 0; trap_e = -1; ncommit = 0; order_ok = 1; vec_ok = 0;
            for (int e = 0; e < 13; e++) begin
                if (!seen && commit_valid) begin
                    if (commit_pc != 32'(4 * ncommit)) order_ok = 0;
                    ncommit++;
                end
                if (!seen && trap_taken) begin seen = 1; trap_e = e; end
                if (seen && e == trap_e + 1) vec_ok = (fetch_pc == VEC && sup_mode);
                stage_fault = '0;
                for (int s = 0; s < 4; s++)
                    if ((TBL[v][1] == s && e == TBL[v][0] + 1 + s) ||
                        (TBL[v][3] == s && e == TBL[v][2] + 1 + s))
                        stage_fault[s] = 1'b1;
                irq_req = (e >= TBL[v][4]);
                @(posedge clk); @(negedge clk);
            end
            stage_fault = '0; irq_req = 1'b0;
            chk(trap_e == TBL[v][6] + 5, $sformatf("R2 trap cycle vec%0d", v), trap_e, TBL[v][6] + 5);
            chk(ncommit == TBL[v][6], $sformatf("R6 older commits vec%0d", v), ncommit, TBL[v][6]);
            chk(order_ok == 1, $sformatf("R10 commit order vec%0d", v), order_ok, 1);
            chk(ecause == 3'(TBL[v][5]), $sformatf("R3 R4 cause vec%0d", v), ecause, TBL[v][5]);
            chk(epc == 32'(4 * TBL[v][6]), $sformatf("R5 epc vec%0d", v), epc, 4 * TBL[v][6]);
            chk(vec_ok == 1, $sformatf("R5 vector and mode vec%0d", v), vec_ok, 1);
        end

        // Directed: a strobe on an empty stage right after reset is ignored (R1)
        do_reset();
        stage_fault = 4'b1000;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        stage_fault = '0;
        seen = 0;
        for (int e = 3; e < 10; e++) begin
            if (trap_taken) seen = 1;
            @(posedge clk); @(negedge clk);
        end
        chk(seen == 0 && !sup_mode, "R1 empty stage strobe", seen, 0);

        // Directed: masked interrupt in supervisor mode, then return (R7, R8)
        do_reset();
        seen = 0; trap_e = -1;
        for (int e = 0; e < 15; e++) begin
            if (trap_taken) begin
                if (trap_e < 0) trap_e = e; else seen = 1;
            end
            if (e == 13)
                chk(commit_valid && commit_pc == VEC, "R7 handler runs while masked", commit_pc, VEC);
            irq_req = (e >= 2);
            eret = (e == 14);
            if (e == 14) irq_req = 1'b0;
            @(posedge clk); @(negedge clk);
        end
        eret = 1'b0;
        chk(trap_e == 7 && epc == 32'h8 && ecause == 3'd5, "R7 bubble replaces pc 8", epc, 32'h8);
        chk(seen == 0, "R7 no injection in supervisor", seen, 0);
        chk(fetch_pc == 32'h8 && !sup_mode, "R8 return pc and mode", fetch_pc, 32'h8);
        seen = 0;
        for (int e = 15; e < 20; e++) begin
            if (commit_valid) seen = 1;
            @(posedge clk); @(negedge clk);
        end
        chk(seen == 0, "R8 flushed slots do not commit", seen, 0);
        chk(commit_valid && commit_pc == 32'h8, "R8 restart commit", commit_pc, 32'h8);

        finish_run();
    end
endmodule